// File: doc/BRIEF.md
# Piecewise-Linear Sine and Cosine Oscillator

This block is a numerically controlled oscillator for feeding quadrature mixers. A 20-bit phase accumulator advances by a tuning word on every enabled clock. Its upper twelve bits, shifted by a phase-offset input, drive two identical phase-to-amplitude converters, one for the sine and one for the cosine. The cosine copy sees the phase advanced by a quarter turn.

Each converter holds no lookup memory and uses no multiplier. It folds the phase into the first quadrant with a ones' complement. It splits the folded phase into one of eight equal segments and a position within that segment. The magnitude comes from a three-operand adder that sums a per-segment start value with two shifted copies of the position, so each segment's slope is a sum of powers of two. The top phase bit then sets the sign of the 8-bit sample.

Top module: `pwl_sincos_nco`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator returns to zero phase and `out_valid`, `sin_out` and `cos_out` are cleared to 0.
- R2: At each rising edge with `en` high, the accumulator advances by `tune_word` modulo 2^20. That edge also captures the sample phase p = (accumulator bits 19..8 before the addition + `phase_ofs`) mod 4096. With `en` low, the accumulator keeps its value.
- R3: Folding: when p bit 10 is 1, the quarter phase is q = 1023 - p[9:0], the ones' complement; otherwise q = p[9:0]. The segment is k = q[9:7] and the position is n = q[6:0].
- R4: The magnitude is B[k] + floor((n*S[k] + 64) / 128). For k = 0..7, B is 0, 25, 49, 71, 90, 106, 117, 125 and S is 24, 24, 20, 18, 16, 12, 8, 2. The magnitude never exceeds 127.
- R5: `sin_out` is the magnitude for phase p when p bit 11 is 0, and its two's complement negation when p bit 11 is 1, as a signed 8-bit value.
- R6: `cos_out` applies R3 to R5 to the phase (p + 1024) mod 4096.
- R7: A sample whose phase was captured at an enabled edge appears on `sin_out` and `cos_out`, with `out_valid` high, right after the next rising edge. `out_valid` is therefore high two edges after `en` was sampled high.
- R8: When `en` was sampled low, `out_valid` is low two edges later and `sin_out` and `cos_out` keep their previous values.
- R9: Whenever `out_valid` is high, sin_out^2 + cos_out^2 lies between 15000 and 16641.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the phase and emit one sample |
| tune_word | input | 20 | Phase increment per enabled clock |
| phase_ofs | input | 12 | Offset added to the truncated phase |
| sin_out | output | 8 | Signed sine sample |
| cos_out | output | 8 | Signed cosine sample |
| out_valid | output | 1 | Samples updated at the last edge |

## Verification
A corrupted accumulator shows up on the very next valid sample as a wrong phase. A sweep of the tuning word, including wrap-around and gaps in `en`, exposes it within one or two clocks. A wrong segment start value, shift pair, fold or sign only appears at particular phases. For that reason, every one of the 4096 phases is driven through the offset input while the accumulator is held at zero. Each result is compared to its exact value two edges later, and the sine–cosine radius is checked on every valid sample.

// File: rtl/pwl_nco_pkg.sv
package pwl_nco_pkg;

  localparam int ACC_W  = 20;
  localparam int PH_W   = 12;
  localparam int SEG_W  = 3;
  localparam int POS_W  = PH_W - 2 - SEG_W;
  localparam int MAG_W  = 7;
  localparam int FRAC_W = 6;
  localparam int TERM_W = POS_W + FRAC_W;
  localparam int OUT_W  = MAG_W + 1;

  localparam logic [2:0] SH_NONE = 3'd7;

  // start value of each segment: rounded sine at the segment start
  function automatic logic [MAG_W-1:0] seg_base(input logic [SEG_W-1:0] k);
    case (k)
      3'd0:    seg_base = 7'd0;
      3'd1:    seg_base = 7'd25;
      3'd2:    seg_base = 7'd49;
      3'd3:    seg_base = 7'd71;
      3'd4:    seg_base = 7'd90;
      3'd5:    seg_base = 7'd106;
      3'd6:    seg_base = 7'd117;
      default: seg_base = 7'd125;
    endcase
  endfunction

  // right shift of the scaled position for slope term t; SH_NONE drops it
  function automatic logic [2:0] seg_shift(input logic [SEG_W-1:0] k, input int t);
    logic [2:0] a, b;
    case (k)
      3'd0:    begin a = 3'd3; b = 3'd4;    end
      3'd1:    begin a = 3'd3; b = 3'd4;    end
      3'd2:    begin a = 3'd3; b = 3'd5;    end
      3'd3:    begin a = 3'd3; b = 3'd6;    end
      3'd4:    begin a = 3'd3; b = SH_NONE; end
      3'd5:    begin a = 3'd4; b = 3'd5;    end
      3'd6:    begin a = 3'd4; b = SH_NONE; end
      default: begin a = 3'd6; b = SH_NONE; end
    endcase
    seg_shift = (t == 0) ? a : b;
  endfunction

endpackage

// File: rtl/pwl_phase_acc.sv
module pwl_phase_acc
  import pwl_nco_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [ACC_W-1:0] tune_word,
  input  logic [PH_W-1:0]  phase_ofs,
  output logic [PH_W-1:0]  ph_sin,
  output logic [PH_W-1:0]  ph_cos,
  output logic             ph_vld
);

  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic [ACC_W-1:0] acc;
  logic [PH_W-1:0]  ph_now;

  assign ph_now = acc[ACC_W-1 -: PH_W] + phase_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      ph_sin <= '0;
      ph_cos <= '0;
      ph_vld <= 1'b0;
    end else begin
      ph_vld <= en;
      if (en) begin
        acc    <= acc + tune_word;
        ph_sin <= ph_now;
        ph_cos <= ph_now + QUARTER;
      end
    end
  end

  // R2: a disabled clock leaves the phase untouched
  a_r2_hold_phase: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

endmodule

// File: rtl/pwl_segment_interp.sv
module pwl_segment_interp
  import pwl_nco_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [POS_W-1:0] pos,
  output logic [MAG_W-1:0] mag
);

  localparam int SUM_W = TERM_W + 2;
  localparam logic [SUM_W-1:0] RND = SUM_W'(1) << (FRAC_W - 1);

  logic [TERM_W-1:0] pos_scaled;
  logic [TERM_W-1:0] term [2];
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  shifted;

  assign pos_scaled = {pos, {FRAC_W{1'b0}}};

  for (genvar t = 0; t < 2; t++) begin : g_slope
    logic [2:0] sh;
    assign sh      = seg_shift(seg, t);
    assign term[t] = (sh == SH_NONE) ? '0 : (pos_scaled >> sh);
  end

  always_comb begin
    sum     = SUM_W'({seg_base(seg), {FRAC_W{1'b0}}}) + SUM_W'(term[0])
            + SUM_W'(term[1]) + RND;
    shifted = sum >> FRAC_W;
    mag     = shifted[MAG_W-1:0];
    // R4: the rounded sum must fit the magnitude width
    a_r4_no_overflow: assert (shifted[SUM_W-1:MAG_W] == '0);
  end

endmodule

// File: rtl/pwl_quadrant_conv.sv
module pwl_quadrant_conv
  import pwl_nco_pkg::*;
(
  input  logic [PH_W-1:0]  phase,
  output logic [OUT_W-1:0] sample
);

  localparam int QW = PH_W - 2;

  logic [QW-1:0]    qphase;
  logic [MAG_W-1:0] mag;
  logic [OUT_W-1:0] mag_ext;

  assign qphase = phase[PH_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];

  pwl_segment_interp i_interp (
    .seg (qphase[QW-1 -: SEG_W]),
    .pos (qphase[POS_W-1:0]),
    .mag (mag)
  );

  assign mag_ext = {1'b0, mag};
  assign sample  = phase[PH_W-1] ? (~mag_ext + 1'b1) : mag_ext;

endmodule

// File: rtl/pwl_sincos_nco.sv
module pwl_sincos_nco
  import pwl_nco_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        tune_word,
  input  logic [PH_W-1:0]         phase_ofs,
  output logic signed [OUT_W-1:0] sin_out,
  output logic signed [OUT_W-1:0] cos_out,
  output logic                    out_valid
);

  localparam int R2_MIN = 15000;
  localparam int R2_MAX = 16641;

  logic [PH_W-1:0]  ph_arr  [2];
  logic [OUT_W-1:0] smp_arr [2];
  logic             ph_vld;

  pwl_phase_acc i_acc (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .tune_word (tune_word),
    .phase_ofs (phase_ofs),
    .ph_sin    (ph_arr[0]),
    .ph_cos    (ph_arr[1]),
    .ph_vld    (ph_vld)
  );

  for (genvar g = 0; g < 2; g++) begin : g_conv
    pwl_quadrant_conv i_conv (
      .phase  (ph_arr[g]),
      .sample (smp_arr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_out   <= '0;
      cos_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= ph_vld;
      if (ph_vld) begin
        sin_out <= smp_arr[0];
        cos_out <= smp_arr[1];
      end
    end
  end

  logic signed [2*OUT_W:0] rad2;
  assign rad2 = sin_out * sin_out + cos_out * cos_out;

  // R7: an enabled edge yields a valid sample two edges later
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    en |-> ##2 out_valid);

  // R8: a disabled edge yields no valid sample two edges later
  a_r8_no_valid: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##2 !out_valid);

  // R8: samples hold while no new one is flagged
  a_r8_hold_out: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(sin_out) && $stable(cos_out)));

  // R9: sine and cosine stay near the unit circle
  a_r9_radius: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (rad2 >= R2_MIN && rad2 <= R2_MAX));

endmodule

// File: tb/test_pwl_sincos_nco.sv
module test_pwl_sincos_nco;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic [19:0]       tune_word = '0;
  logic [11:0]       phase_ofs = '0;
  logic signed [7:0] sin_out, cos_out;
  logic              out_valid;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [19:0] m_acc = '0;
  logic        m_v1 = 1'b0;
  logic [11:0] m_ph = '0;
  logic        e_valid = 1'b0;
  logic [7:0]  e_sin = '0, e_cos = '0;

  always #5 clk = ~clk;

  pwl_sincos_nco i_pwl_sincos_nco (
    .clk (clk), .rst (rst), .en (en), .tune_word (tune_word),
    .phase_ofs (phase_ofs), .sin_out (sin_out), .cos_out (cos_out),
    .out_valid (out_valid)
  );

  function automatic int base_of(input int k);
    int t [8] = '{0, 25, 49, 71, 90, 106, 117, 125};
    return t[k];
  endfunction

  function automatic int slope_of(input int k);
    int t [8] = '{24, 24, 20, 18, 16, 12, 8, 2};
    return t[k];
  endfunction

  function automatic logic [7:0] exp_smp(input logic [11:0] p);
    int q, k, n, m;
    q = p[10] ? 1023 - int'(p[9:0]) : int'(p[9:0]);
    k = q / 128;
    n = q % 128;
    m = base_of(k) + (n * slope_of(k) + 64) / 128;
    return p[11] ? 8'(-m) : 8'(m);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_v1 = 1'b0; m_ph = '0;
    e_valid = 1'b0; e_sin = '0; e_cos = '0;
  endtask

  // one clock: drive, model the edge, compare away from the edge
  task automatic step(input logic e, input logic [19:0] w, input logic [11:0] o,
                      input string tag);
    int r2;
    en = e; tune_word = w; phase_ofs = o;
    @(posedge clk);
    e_valid = m_v1;
    if (m_v1) begin
      e_sin = exp_smp(m_ph);
      e_cos = exp_smp(m_ph + 12'd1024);
    end
    m_v1 = e;
    if (e) begin
      m_ph  = m_acc[19:8] + o;
      m_acc = m_acc + w;
    end
    @(negedge clk);
    check({tag, " valid"}, int'(out_valid), int'(e_valid));
    check({tag, " sin"}, int'(sin_out), int'($signed(e_sin)));
    check({tag, " cos"}, int'(cos_out), int'($signed(e_cos)));
    if (out_valid) begin
      r2 = int'(sin_out) * int'(sin_out) + int'(cos_out) * int'(cos_out);
      check("R9 radius in range", int'(r2 >= 15000 && r2 <= 16641), 1);
    end
  endtask

  task automatic t_reset();
    en = 1'b0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset sin", int'(sin_out), 0);
    check("R1 reset cos", int'(cos_out), 0);
  endtask

  task automatic t_offset_sweep();
    t_reset();
    for (int i = 0; i < 4096; i++) step(1'b1, 20'd0, 12'(i), "R3 R4 R5 R6 sweep");
    step(1'b0, 20'd0, 12'd0, "R4 sweep tail");
    step(1'b0, 20'd0, 12'd0, "R4 sweep tail");
  endtask

  task automatic corner(input logic [11:0] p, input int s, input int c);
    step(1'b1, 20'd0, p, "R7 corner");
    step(1'b0, 20'd0, 12'd0, "R7 corner");
    check("R5 corner sin", int'(sin_out), s);
    check("R6 corner cos", int'(cos_out), c);
  endtask

  task automatic t_corners();
    t_reset();
    corner(12'd0,    0,    127);
    corner(12'd512,  90,   89);
    corner(12'd1024, 127,  0);
    corner(12'd2048, 0,   -127);
    corner(12'd3072, -127, 0);
    corner(12'd4095, 0,    127);
  endtask

  task automatic t_accumulate();
    t_reset();
    for (int i = 0; i < 300; i++) step(1'b1, 20'h00100, 12'd0, "R2 unit step");
    for (int i = 0; i < 200; i++) step(1'b1, 20'hFFFFF, 12'd7, "R2 wrap down");
    for (int i = 0; i < 200; i++) step(1'b1, 20'h12345, 12'd100, "R2 odd word");
    for (int i = 0; i < 50; i++)  step(1'b1, 20'h80000, 12'd300, "R2 half turn");
  endtask

  task automatic t_enable_gaps();
    logic pat [12] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 0, 1, 0};
    t_reset();
    for (int r = 0; r < 20; r++)
      for (int i = 0; i < 12; i++) step(pat[i], 20'h04321, 12'd0, "R8 R2 gaps");
    step(1'b0, 20'h04321, 12'd0, "R8 idle");
    step(1'b0, 20'h04321, 12'd0, "R8 idle");
    check("R8 idle valid low", int'(out_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_offset_sweep();
    t_accumulate();
    t_enable_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule